// File: doc/BRIEF.md
# Iterated 32x32 Integer Multiplier

This block multiplies two 32-bit operands into a full 64-bit product. It does this with one 16x16 multiplier core that is used four times in a row. The core has a single internal register stage. Each pass multiplies one half of the first operand by one half of the second. The partial product is sign- or zero-extended, shifted by 0, 16 or 32 bits, and added into a 64-bit accumulator.

A one-cycle `start_i` strobe captures the operands and two per-operation selects:

- `signed_i` picks two's-complement or unsigned arithmetic.
- `flag_en_i` asks for the condition flags to be updated from the result.

When the last partial product has been accumulated, `done_o` pulses for one cycle. The product is then presented, and it stays on the port until the next accepted start. The surrounding pipeline owns forwarding, hazards and register write-back. This block only computes the product and signals completion.

Top module: `iter_mul32`

## Requirements
- R1: With `signed_i`=0 at start, `product_o` at the `done_o` pulse equals the unsigned 64-bit product of `op_a_i` and `op_b_i`.
- R2: With `signed_i`=1 at start, `product_o` at the `done_o` pulse equals the two's-complement 64-bit product of the operands read as signed 32-bit values.
- R3: `done_o` is high for exactly one cycle. It rises on the fifth rising clock edge after the edge that accepted the start (start edge counted as edge 0).
- R4: A `start_i` pulse while a multiply is in progress is ignored. The running operation's product, flags and `done_o` timing are unchanged, and no extra `done_o` pulse follows.
- R5: With `flag_en_i`=1 at start, the flags update at the `done_o` pulse as follows: N = `product_o[31]`, Z = 1 exactly when `product_o[31:0]` is zero, V = 0 and C = 0.
- R6: With `flag_en_i`=0 at start, all four flags keep their previous values.
- R7: After reset `product_o` is zero, `done_o` is low and all four flags are low.
- R8: After `done_o`, `product_o` and the flags hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier |
| signed_i | input | 1 | 1 = signed, 0 = unsigned |
| flag_en_i | input | 1 | 1 = update flags from this result |
| product_o | output | 64 | 64-bit product |
| done_o | output | 1 | One-cycle completion pulse |
| flag_n_o | output | 1 | Negative flag (bit 31 of result) |
| flag_z_o | output | 1 | Zero flag (low word zero) |
| flag_v_o | output | 1 | Overflow flag, cleared on update |
| flag_c_o | output | 1 | Carry flag, cleared on update |

## Verification
The bench sweeps the full cross product of a set of corner operands in both modes. The set includes 0, 1, 0x80000000, 0xFFFFFFFF and half-word boundary values, and a pseudo-random stream follows the sweep.

The corners target specific faults:
- A design that sign-extended the lower halves, or left the upper halves unsigned in signed mode, would fail on 0xFFFFFFFF and 0x80000000.
- A wrong shift for the cross terms would corrupt products with both halves non-zero.
- A dropped pipeline beat would lose one partial product or move `done_o` off the fifth edge.

A start injected mid-operation exposes a design that re-latches operands or restarts its pass count. Alternating the flag select catches flags that update when not asked to, or that are taken from the upper word.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;
  localparam int unsigned PASS_N = 4;
  localparam int unsigned TAG_W  = 2;

  typedef logic [TAG_W-1:0] tag_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/mul_core16.sv
// Half-width signed multiplier with one output register stage.
module mul_core16 #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned IN_W  = HALF_W + 1,
  localparam int unsigned OUT_W = 2 * IN_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_vld_i,
  input  iter_mul_pkg::tag_t      in_tag_i,
  input  logic signed [IN_W-1:0]  a_i,
  input  logic signed [IN_W-1:0]  b_i,
  output logic                    out_vld_o,
  output iter_mul_pkg::tag_t      out_tag_o,
  output logic signed [OUT_W-1:0] prod_o
);
  logic signed [OUT_W-1:0] prod_d;

  assign prod_d = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o <= 1'b0;
      out_tag_o <= '0;
      prod_o    <= '0;
    end else begin
      out_vld_o <= in_vld_i;
      if (in_vld_i) begin
        out_tag_o <= in_tag_i;
        prod_o    <= prod_d;
      end
    end
  end

  // passes arrive in issue order
  assert_tag_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && out_tag_o != iter_mul_pkg::tag_t'(iter_mul_pkg::PASS_N - 1)
      |=> out_vld_o && out_tag_o == $past(out_tag_o) + 1'b1);
endmodule

// File: rtl/mul_seq.sv
// Pass sequencer: accepts start when idle, issues PASS_N passes, signals done.
module mul_seq (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               last_acc_i,
  output logic               accept_o,
  output logic               busy_o,
  output logic               iss_vld_o,
  output iter_mul_pkg::tag_t iss_tag_o,
  output logic               done_o
);
  import iter_mul_pkg::*;

  localparam tag_t LAST_TAG = tag_t'(PASS_N - 1);

  assign accept_o = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      iss_vld_o <= 1'b0;
      iss_tag_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= last_acc_i;
      if (accept_o) begin
        busy_o    <= 1'b1;
        iss_vld_o <= 1'b1;
        iss_tag_o <= '0;
      end else begin
        if (last_acc_i) busy_o <= 1'b0;
        if (iss_vld_o) begin
          iss_tag_o <= iss_tag_o + 1'b1;
          if (iss_tag_o == LAST_TAG) iss_vld_o <= 1'b0;
        end
      end
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && iss_vld_o |=> iss_tag_o == $past(iss_tag_o) + 1'b1);
endmodule

// File: rtl/mul_acc.sv
// 64-bit accumulator of shifted partial products.
module mul_acc #(
  parameter int unsigned OP_W   = 32,
  localparam int unsigned HALF_W = OP_W / 2,
  localparam int unsigned PP_W   = 2 * (HALF_W + 1),
  localparam int unsigned RES_W  = 2 * OP_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   add_vld_i,
  input  iter_mul_pkg::tag_t     add_tag_i,
  input  logic signed [PP_W-1:0] pp_i,
  output logic [RES_W-1:0]       acc_d_o,
  output logic [RES_W-1:0]       acc_q_o
);
  logic [RES_W-1:0] pp_ext;
  logic [RES_W-1:0] pp_shift;

  assign pp_ext = {{(RES_W-PP_W){pp_i[PP_W-1]}}, pp_i};

  always_comb begin
    unique case (add_tag_i)
      2'd0:    pp_shift = pp_ext;
      2'd3:    pp_shift = pp_ext << (2 * HALF_W);
      default: pp_shift = pp_ext << HALF_W;
    endcase
  end

  assign acc_d_o = acc_q_o + pp_shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q_o <= '0;
    else if (clr_i)     acc_q_o <= '0;
    else if (add_vld_i) acc_q_o <= acc_d_o;
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !add_vld_i |=> $stable(acc_q_o));
endmodule

// File: rtl/mul_flags.sv
// Condition flags taken from the low result word.
module mul_flags #(
  parameter int unsigned LO_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [LO_W-1:0]   res_lo_i,
  output iter_mul_pkg::cc_t cc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_o <= '0;
    end else if (upd_i) begin
      cc_o.n <= res_lo_i[LO_W-1];
      cc_o.z <= (res_lo_i == '0);
      cc_o.v <= 1'b0;
      cc_o.c <= 1'b0;
    end
  end

  assert_flags_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(cc_o));

  assert_vc_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !cc_o.v && !cc_o.c);
endmodule

// File: rtl/iter_mul32.sv
module iter_mul32 #(
  parameter int unsigned OP_W = 32,
  localparam int unsigned HALF_W = OP_W / 2,
  localparam int unsigned IN_W   = HALF_W + 1,
  localparam int unsigned PP_W   = 2 * IN_W,
  localparam int unsigned RES_W  = 2 * OP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic             signed_i,
  input  logic             flag_en_i,
  output logic [RES_W-1:0] product_o,
  output logic             done_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_v_o,
  output logic             flag_c_o
);
  import iter_mul_pkg::*;

  localparam tag_t LAST_TAG = tag_t'(PASS_N - 1);

  logic              accept, busy, iss_vld, core_vld, last_acc;
  tag_t              iss_tag, core_tag;
  logic [OP_W-1:0]   a_q, b_q;
  logic              sgn_q, fen_q;
  logic signed [IN_W-1:0] a_half, b_half;
  logic signed [PP_W-1:0] pp;
  logic [RES_W-1:0]  acc_d, acc_q;
  cc_t               cc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      sgn_q <= 1'b0;
      fen_q <= 1'b0;
    end else if (accept) begin
      a_q   <= op_a_i;
      b_q   <= op_b_i;
      sgn_q <= signed_i;
      fen_q <= flag_en_i;
    end
  end

  // tag[1] picks the half of A, tag[0] the half of B; upper halves carry sign
  function automatic logic signed [IN_W-1:0] pick_half(
      input logic [OP_W-1:0] v, input logic hi, input logic sg);
    if (hi) return {sg & v[OP_W-1], v[OP_W-1:HALF_W]};
    else    return {1'b0, v[HALF_W-1:0]};
  endfunction

  assign a_half   = pick_half(a_q, iss_tag[1], sgn_q);
  assign b_half   = pick_half(b_q, iss_tag[0], sgn_q);
  assign last_acc = core_vld && (core_tag == LAST_TAG);

  mul_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_acc_i (last_acc),
    .accept_o   (accept),
    .busy_o     (busy),
    .iss_vld_o  (iss_vld),
    .iss_tag_o  (iss_tag),
    .done_o     (done_o)
  );

  mul_core16 #(.HALF_W(HALF_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (iss_vld),
    .in_tag_i  (iss_tag),
    .a_i       (a_half),
    .b_i       (b_half),
    .out_vld_o (core_vld),
    .out_tag_o (core_tag),
    .prod_o    (pp)
  );

  mul_acc #(.OP_W(OP_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .add_vld_i (core_vld),
    .add_tag_i (core_tag),
    .pp_i      (pp),
    .acc_d_o   (acc_d),
    .acc_q_o   (acc_q)
  );

  mul_flags #(.LO_W(OP_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (last_acc && fen_q),
    .res_lo_i (acc_d[OP_W-1:0]),
    .cc_o     (cc)
  );

  assign product_o = acc_q;
  assign flag_n_o  = cc.n;
  assign flag_z_o  = cc.z;
  assign flag_v_o  = cc.v;
  assign flag_c_o  = cc.c;

  assert_ops_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(a_q) && $stable(b_q) && $stable(sgn_q));

  assert_done_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_acc |=> done_o && !busy);

  assert_flag_n_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fen_q |-> flag_n_o == product_o[OP_W-1]);
endmodule

// File: tb/iter_mul32_tb_top.sv
module iter_mul32_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sgn = 1'b0, fen = 1'b0;
  logic [63:0] product;
  logic        done, fn, fz, fv, fc;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic       exp_n = 0, exp_z = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2 clk = ~clk;

  iter_mul32 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .op_a_i(op_a), .op_b_i(op_b), .signed_i(sgn), .flag_en_i(fen),
    .product_o(product), .done_o(done),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b, logic s);
    longint sa, sb;
    longint unsigned ua, ub;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    ua = {32'b0, a};
    ub = {32'b0, b};
    return ua * ub;
  endfunction

  // Issue one multiply from a negedge; optionally inject a start mid-flight.
  task automatic run_op(logic [31:0] a, logic [31:0] b, logic s, logic f,
                        bit inject, bit hold_chk);
    logic [63:0] expv;
    string rq;
    expv = ref_mul(a, b, s);
    rq = s ? "R2" : "R1";
    op_a = a; op_b = b; sgn = s; fen = f; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      if (inject && k == 2) begin
        op_a = ~a; op_b = b ^ 32'h1234_5678; sgn = ~s; fen = ~f; start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (k < 5) begin
        if (done !== 1'b0) chk("R3", {63'b0, done}, 64'd0);
      end
    end
    chk("R3", {63'b0, done}, 64'd1);
    chk(rq, product, expv);
    if (f) begin
      exp_n = expv[31];
      exp_z = (expv[31:0] == 32'd0);
    end
    chk(f ? "R5" : "R6", {60'b0, fn, fz, fv, fc}, {60'b0, exp_n, exp_z, 2'b00});
    if (inject) chk("R4", product, expv);
    if (hold_chk || inject) begin
      for (int k = 0; k < 6; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (done !== 1'b0) chk(inject ? "R4" : "R3", {63'b0, done}, 64'd0);
      end
      chk("R8", product, expv);
      chk("R8", {62'b0, fn, fz}, {62'b0, exp_n, exp_z});
    end
  endtask

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [8];
    corners = '{32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF,
                32'h7FFF_FFFF, 32'h0000_FFFF, 32'h0001_0000, 32'hFFFF_0000};
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7", product, 64'd0);
    chk("R7", {60'b0, done, fn, fz, fv, fc}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(corners[i], corners[j], m[0], ((i + j) % 3) != 0, 1'b0, (i == j));

    // flags must survive a non-updating op
    run_op(32'h0000_0000, 32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(32'h8000_0001, 32'h0000_0003, 1'b1, 1'b0, 1'b0, 1'b1);

    for (int r = 0; r < 4; r++)
      run_op(corners[r + 2], corners[7 - r], r[0], 1'b1, 1'b1, 1'b0);

    for (int r = 0; r < 300; r++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr * 32'h9E37_79B9;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      run_op(a, b, r[0], r[1], (r % 37) == 5, (r % 11) == 3);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule